// File: doc/BRIEF.md
# Head-Per-Track Disk Transfer Address Sequencer

This block keeps the character-level transfer position for a head-per-track disk controller. Data moves as 12-bit characters. Two characters are packed into each 24-bit word of a sector buffer memory, and the memory is modelled inside the block as a synchronous RAM. A disk address register holds three fields: logical unit in the upper bits, track in the middle bits and sector in the low bits. A character pointer indexes the characters of the current sector. Each accepted read or write strobe uses the pair to form a buffer word address and a half select, and then moves the pointer on by one. When a sector is used up, the disk address steps in one of two wrap modes.

Software-side control arrives as single-cycle strobes. An address load supplies the start sector and the wrap mode, and is taken only while no transfer is open. A connect opens a transfer. An end strobe closes it, and if the transfer was a write that stopped part-way through a sector, it zero-fills the rest of that sector. An 8-bit protect mask, one bit per logical unit, blocks writes. Accesses past the last fitted unit or to a protected unit abort the transfer and raise a sticky error.

The geometry is set by parameters: unit, track and sector field widths, words per sector, and the number of fitted units. The defaults are kept small for elaboration (3/2/2 field bits, 8 words per sector, 6 fitted units). A full-size build uses 3/6/6 bits and 64 words.

Top module: `hpt_xfer_seq`

## Requirements
- R1: After reset the disk address and character pointer are zero, the wrap mode is cross-track, and error, busy, active, rd_valid and xfer_abort are all low.
- R2: addr_ld loads disk_addr from the low address-width bits of the 24-bit addr_ld_word and captures ld_in_track as the wrap mode. It does this only when no transfer is active and the block is not busy; at other times the strobe is ignored.
- R3: conn_stb, when not busy, clears the error flag and the character pointer and makes the transfer active.
- R4: An accepted strobe registers acc_addr = disk_addr*WORDS + (char_ptr>>1) and acc_lo = char_ptr bit 0, then adds one to the pointer.
- R5: A read returns the upper character (bits 23:12) of the word when the pointer is even and the lower character (bits 11:0) when it is odd. rd_char and rd_valid appear two clock edges after the edge that accepts the strobe.
- R6: An even-pointer write stores {char, 12'h000} into the word. An odd-pointer write keeps the upper half and ORs the character into the lower half. An odd write holds busy for one extra cycle.
- R7: When the pointer moves on from 2*WORDS-1, it becomes 0 and the disk address steps. In cross-track mode the combined track+sector field increments, wrapping to zero inside the unit, and the unit field never changes.
- R8: In in-track mode (ld_in_track=1) only the sector field increments, wrapping to zero, and the unit and track fields stay unchanged.
- R9: A write to a unit whose wp_mask bit is set leaves memory and the pointer unchanged. It pulses xfer_abort for one cycle, sets err_flag and clears active.
- R10: A read or write while the unit field is at or above the number of fitted units aborts in the same way as R9 and produces no rd_valid.
- R11: Read and write strobes are ignored while no transfer is active or while busy: the pointer does not move, memory is not written and no read data is returned.
- R12: end_stb with end_wr=1 and a nonzero pointer zero-fills words ceil(ptr/2) through WORDS-1 of the current sector, one per clock. It then steps the disk address in the current mode and clears the pointer. busy stays high for (WORDS - ceil(ptr/2)) + 1 cycles. With a zero pointer, no fill happens.
- R13: end_stb clears active. With end_wr=0 it neither writes memory nor changes the disk address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conn_stb | input | 1 | Open a transfer |
| addr_ld | input | 1 | Load disk address and wrap mode |
| addr_ld_word | input | 24 | Data word carrying the new address in its low bits |
| ld_in_track | input | 1 | Wrap mode captured with the load: 1 = within track |
| wp_mask | input | 8 | Write-protect bit per logical unit |
| rd_stb | input | 1 | Read one character |
| wr_stb | input | 1 | Write one character |
| wr_char | input | 12 | Character to write |
| end_stb | input | 1 | Close the transfer |
| end_wr | input | 1 | Closing transfer was a write (enables fill) |
| rd_char | output | 12 | Returned character |
| rd_valid | output | 1 | rd_char valid this cycle |
| acc_addr | output | 10 | Buffer word address of the last accepted access |
| acc_lo | output | 1 | Half select of the last accepted access (1 = lower) |
| disk_addr | output | 7 | Unit, track and sector register |
| char_ptr | output | 4 | Character pointer within the sector |
| active | output | 1 | Transfer open |
| busy | output | 1 | Odd-write merge or fill in progress |
| err_flag | output | 1 | Sticky error |
| xfer_abort | output | 1 | One-cycle abort pulse (error and end of record) |

## Verification
The bench aims at the carry paths of the address step. One case is sector into track with the unit held fixed. Another is the full track+sector wrap inside a unit. A third is in-track mode, where a wrong design would leak a carry into the track or unit bits and later reads would come back from the wrong sector. It also checks that an odd write ORs into an existing lower half rather than overwriting it, that a strobe arriving during the merge cycle does not move the pointer twice, and that protected or out-of-range accesses leave stored words intact. For the fill, it covers a mid-sector stop (an even write must have cleared the lower half, and later words must read as zero), an odd stop where no word remains to clear but the address still steps, and a zero pointer where nothing may happen. It also counts the busy cycles of each case.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int CHAR_W = 12;
  localparam int WORD_W = 2 * CHAR_W;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_ODD  = 2'd1,
    ST_FILL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/hpt_buf_ram.sv
module hpt_buf_ram #(
  parameter int AW    = 10,
  parameter int DW    = 24,
  parameter int DEPTH = 768
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // read-first single port, block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/hpt_addr_step.sv
module hpt_addr_step #(
  parameter int LUN_W = 3,
  parameter int TRK_W = 2,
  parameter int SEC_W = 2
) (
  input  logic [LUN_W+TRK_W+SEC_W-1:0] da_in,
  input  logic                         in_track,
  output logic [LUN_W+TRK_W+SEC_W-1:0] da_out
);
  localparam int DA_W = LUN_W + TRK_W + SEC_W;
  localparam int TS_W = TRK_W + SEC_W;

  always_comb begin
    if (in_track)
      da_out = {da_in[DA_W-1:SEC_W], SEC_W'(da_in[SEC_W-1:0] + 1'b1)};
    else
      da_out = {da_in[DA_W-1:TS_W], TS_W'(da_in[TS_W-1:0] + 1'b1)};
  end
endmodule

// File: rtl/hpt_xfer_seq.sv
module hpt_xfer_seq
  import hpt_pkg::*;
#(
  parameter int LUN_W        = 3,
  parameter int TRK_W        = 2,
  parameter int SEC_W        = 2,
  parameter int WPS_W        = 3,
  parameter int UNITS_FITTED = 6,
  parameter int LOAD_W       = 24
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  conn_stb,
  input  logic                                  addr_ld,
  input  logic [LOAD_W-1:0]                     addr_ld_word,
  input  logic                                  ld_in_track,
  input  logic [(1<<LUN_W)-1:0]                 wp_mask,
  input  logic                                  rd_stb,
  input  logic                                  wr_stb,
  input  logic [CHAR_W-1:0]                     wr_char,
  input  logic                                  end_stb,
  input  logic                                  end_wr,
  output logic [CHAR_W-1:0]                     rd_char,
  output logic                                  rd_valid,
  output logic [LUN_W+TRK_W+SEC_W+WPS_W-1:0]    acc_addr,
  output logic                                  acc_lo,
  output logic [LUN_W+TRK_W+SEC_W-1:0]          disk_addr,
  output logic [WPS_W:0]                        char_ptr,
  output logic                                  active,
  output logic                                  busy,
  output logic                                  err_flag,
  output logic                                  xfer_abort
);
  localparam int DA_W  = LUN_W + TRK_W + SEC_W;
  localparam int WORDS = 1 << WPS_W;
  localparam int PTR_W = WPS_W + 1;
  localparam int AW    = DA_W + WPS_W;
  localparam int DEPTH = UNITS_FITTED << (TRK_W + SEC_W + WPS_W);

  seq_state_e        state_q;
  logic [DA_W-1:0]   da_q, da_stepped;
  logic [PTR_W-1:0]  ptr_q, fill_idx_q, fill_start;
  logic              in_track_q, err_q, act_q, abort_q;
  logic [AW-1:0]     odd_addr_q, acc_addr_q, cur_addr;
  logic [CHAR_W-1:0] odd_char_q, rd_char_q;
  logic              rd_pend_q, rd_lo_q, rd_valid_q, acc_lo_q;
  logic              ram_we;
  logic [AW-1:0]     ram_addr;
  logic [WORD_W-1:0] ram_wd, ram_q;
  logic [LUN_W-1:0]  unit;
  logic              in_range, prot, can_xfer, rd_go, wr_go, rd_ok, wr_ok, bad;
  logic              ptr_last, end_go, fill_need, ld_ok;
  logic              unused_ld_bits;

  assign unused_ld_bits = ^addr_ld_word[LOAD_W-1:DA_W];

  hpt_addr_step #(.LUN_W(LUN_W), .TRK_W(TRK_W), .SEC_W(SEC_W)) u_step (
    .da_in(da_q), .in_track(in_track_q), .da_out(da_stepped)
  );

  hpt_buf_ram #(.AW(AW), .DW(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wd), .rdata(ram_q)
  );

  assign unit       = da_q[DA_W-1 -: LUN_W];
  assign in_range   = int'(unit) < UNITS_FITTED;
  assign prot       = wp_mask[unit];
  assign cur_addr   = {da_q, ptr_q[PTR_W-1:1]};
  assign can_xfer   = act_q && (state_q == ST_RUN);
  assign rd_go      = can_xfer && rd_stb;
  assign wr_go      = can_xfer && wr_stb && !rd_stb;
  assign rd_ok      = rd_go && in_range;
  assign wr_ok      = wr_go && in_range && !prot;
  assign bad        = (rd_go && !in_range) || (wr_go && (!in_range || prot));
  assign ptr_last   = (ptr_q == {PTR_W{1'b1}});
  assign end_go     = can_xfer && end_stb && !rd_stb && !wr_stb;
  assign fill_need  = end_go && end_wr && (ptr_q != '0) && in_range && !prot;
  assign fill_start = PTR_W'(({1'b0, ptr_q} + 1'b1) >> 1);
  assign ld_ok      = addr_ld && !act_q && (state_q == ST_RUN);

  // memory port steering
  always_comb begin
    ram_we   = 1'b0;
    ram_addr = cur_addr;
    ram_wd   = '0;
    case (state_q)
      ST_ODD: begin
        ram_we   = 1'b1;
        ram_addr = odd_addr_q;
        ram_wd   = {ram_q[WORD_W-1:CHAR_W], ram_q[CHAR_W-1:0] | odd_char_q};
      end
      ST_FILL: begin
        ram_addr = {da_q, fill_idx_q[WPS_W-1:0]};
        ram_we   = (fill_idx_q != PTR_W'(WORDS));
      end
      default: begin
        if (wr_ok && !ptr_q[0]) begin
          ram_we = 1'b1;
          ram_wd = {wr_char, {CHAR_W{1'b0}}};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      da_q       <= '0;
      ptr_q      <= '0;
      in_track_q <= 1'b0;
      err_q      <= 1'b0;
      act_q      <= 1'b0;
      abort_q    <= 1'b0;
      fill_idx_q <= '0;
      odd_addr_q <= '0;
      odd_char_q <= '0;
      acc_addr_q <= '0;
      acc_lo_q   <= 1'b0;
      rd_pend_q  <= 1'b0;
      rd_lo_q    <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_char_q  <= '0;
    end else begin
      abort_q    <= 1'b0;
      rd_pend_q  <= rd_ok;
      rd_lo_q    <= ptr_q[0];
      rd_valid_q <= rd_pend_q;
      if (rd_pend_q)
        rd_char_q <= rd_lo_q ? ram_q[CHAR_W-1:0] : ram_q[WORD_W-1:CHAR_W];
      case (state_q)
        ST_RUN: begin
          if (ld_ok) begin
            da_q       <= addr_ld_word[DA_W-1:0];
            in_track_q <= ld_in_track;
          end
          if (conn_stb) begin
            act_q <= 1'b1;
            err_q <= 1'b0;
            ptr_q <= '0;
          end else if (rd_ok || wr_ok) begin
            acc_addr_q <= cur_addr;
            acc_lo_q   <= ptr_q[0];
            if (ptr_last) begin
              ptr_q <= '0;
              da_q  <= da_stepped;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
            if (wr_ok && ptr_q[0]) begin
              state_q    <= ST_ODD;
              odd_addr_q <= cur_addr;
              odd_char_q <= wr_char;
            end
          end else if (bad) begin
            abort_q <= 1'b1;
            err_q   <= 1'b1;
            act_q   <= 1'b0;
          end else if (end_go) begin
            act_q <= 1'b0;
            if (fill_need) begin
              state_q    <= ST_FILL;
              fill_idx_q <= fill_start;
            end
          end
        end
        ST_ODD: state_q <= ST_RUN;
        ST_FILL: begin
          if (fill_idx_q == PTR_W'(WORDS)) begin
            da_q    <= da_stepped;
            ptr_q   <= '0;
            state_q <= ST_RUN;
          end else begin
            fill_idx_q <= fill_idx_q + 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign rd_char    = rd_char_q;
  assign rd_valid   = rd_valid_q;
  assign acc_addr   = acc_addr_q;
  assign acc_lo     = acc_lo_q;
  assign disk_addr  = da_q;
  assign char_ptr   = ptr_q;
  assign active     = act_q;
  assign busy       = (state_q != ST_RUN);
  assign err_flag   = err_q;
  assign xfer_abort = abort_q;

  // R7
  unit_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_ok |=> $stable(da_q[DA_W-1 -: LUN_W]));

  // R8
  track_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_ok && in_track_q) |=> $stable(da_q[DA_W-1:SEC_W]));

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> abort_q);

  // R11
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_q && state_q == ST_RUN) |-> !ram_we);

  // R12
  fill_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL) |-> !act_q);

  // R3
  conn_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (conn_stb && state_q == ST_RUN) |=> (ptr_q == '0 && !err_q && act_q));

  // R6
  odd_merge_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ODD) |=> (state_q == ST_RUN));
endmodule

// File: tb/sim_hpt_xfer_seq.sv
module sim_hpt_xfer_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conn_stb = 0, addr_ld = 0, ld_in_track = 0;
  logic [23:0] addr_ld_word = '0;
  logic [7:0]  wp_mask = '0;
  logic        rd_stb = 0, wr_stb = 0, end_stb = 0, end_wr = 0;
  logic [11:0] wr_char = '0;
  logic [11:0] rd_char;
  logic        rd_valid, acc_lo, active, busy, err_flag, xfer_abort;
  logic [9:0]  acc_addr;
  logic [6:0]  disk_addr;
  logic [3:0]  char_ptr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [11:0] exp_q[$];
  logic [23:0] shadow [1024];
  logic [6:0]  m_da;
  int          m_ptr;
  logic        m_in_track;

  always #2 clk = ~clk;

  hpt_xfer_seq u0 (
    .clk(clk), .rst(rst), .conn_stb(conn_stb), .addr_ld(addr_ld),
    .addr_ld_word(addr_ld_word), .ld_in_track(ld_in_track), .wp_mask(wp_mask),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_char(wr_char), .end_stb(end_stb),
    .end_wr(end_wr), .rd_char(rd_char), .rd_valid(rd_valid), .acc_addr(acc_addr),
    .acc_lo(acc_lo), .disk_addr(disk_addr), .char_ptr(char_ptr), .active(active),
    .busy(busy), .err_flag(err_flag), .xfer_abort(xfer_abort)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] mk_da(input int u, input int t, input int s);
    return {3'(u), 2'(t), 2'(s)};
  endfunction

  task automatic m_adv();
    if (m_ptr == 15) begin
      m_ptr = 0;
      if (m_in_track) m_da = {m_da[6:2], 2'(m_da[1:0] + 1)};
      else            m_da = {m_da[6:4], 4'(m_da[3:0] + 1)};
    end else m_ptr++;
  endtask

  task automatic do_load(input logic [23:0] w, input logic mode, input bit upd);
    addr_ld = 1; addr_ld_word = w; ld_in_track = mode;
    @(negedge clk);
    addr_ld = 0;
    if (upd) begin m_da = w[6:0]; m_in_track = mode; end
  endtask

  task automatic do_conn();
    conn_stb = 1;
    @(negedge clk);
    conn_stb = 0;
    m_ptr = 0;
  endtask

  task automatic do_write(input logic [11:0] c);
    int a;
    a = int'(m_da) * 8 + m_ptr / 2;
    if (m_ptr % 2 == 0) shadow[a] = {c, 12'h000};
    else shadow[a] = {shadow[a][23:12], shadow[a][11:0] | c};
    m_adv();
    wr_stb = 1; wr_char = c;
    @(negedge clk);
    wr_stb = 0;
    @(negedge clk);
  endtask

  task automatic do_read();
    int a;
    a = int'(m_da) * 8 + m_ptr / 2;
    exp_q.push_back((m_ptr % 2 == 0) ? shadow[a][23:12] : shadow[a][11:0]);
    m_adv();
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    @(negedge clk);
  endtask

  task automatic do_end(input logic wr);
    end_stb = 1; end_wr = wr;
    @(negedge clk);
    end_stb = 0; end_wr = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 R10 R11 unexpected read actual %0h expected none", rd_char);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        if (rd_char !== e) begin
          errors++;
          $display("FAIL R5 read data actual %0h expected %0h", rd_char, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    m_da = '0; m_ptr = 0; m_in_track = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 disk_addr", disk_addr, 0);
    chk("R1 char_ptr", char_ptr, 0);
    chk("R1 flags", {busy, err_flag, active, rd_valid, xfer_abort}, 0);

    // R2 load masks to low bits
    do_load(24'hFFFF80 | 24'(mk_da(0, 1, 3)), 1'b0, 1);
    chk("R2 load masked", disk_addr, mk_da(0, 1, 3));
    do_conn();
    chk("R3 active after connect", {active, char_ptr}, 5'h10);
    do_load(24'h000055, 1'b1, 0);
    chk("R2 load ignored while active", disk_addr, mk_da(0, 1, 3));

    // R4 address/half select, R7 sector->track carry
    do_write(12'h100);
    chk("R4 acc_addr even", {acc_addr, acc_lo}, {10'(mk_da(0, 1, 3) * 8), 1'b0});
    do_write(12'h101);
    chk("R4 acc_addr odd", {acc_addr, acc_lo}, {10'(mk_da(0, 1, 3) * 8), 1'b1});
    chk("R4 ptr advance", char_ptr, 2);
    for (int k = 2; k < 16; k++) do_write(12'(12'h100 + k));
    chk("R7 ptr wraps", char_ptr, 0);
    chk("R7 carry into track", disk_addr, mk_da(0, 2, 0));
    do_write(12'hA05);
    do_write(12'h30C);
    // R13 end without write flag
    do_end(1'b0);
    chk("R13 no fill busy", busy, 0);
    chk("R13 addr kept, inactive", {disk_addr, active}, {mk_da(0, 2, 0), 1'b0});

    // R5 read back, crossing into next sector
    do_load(24'(mk_da(0, 1, 3)), 1'b0, 1);
    do_conn();
    for (int k = 0; k < 18; k++) do_read();
    chk("R7 read crossing addr", disk_addr, mk_da(0, 2, 0));
    do_end(1'b0);

    // R6 odd write ORs; R11 strobe during merge ignored
    do_load(24'(mk_da(0, 2, 0)), 1'b0, 1);
    do_conn();
    do_read();
    wr_stb = 1; wr_char = 12'h0F0;
    shadow[int'(mk_da(0, 2, 0)) * 8][11:0] = shadow[int'(mk_da(0, 2, 0)) * 8][11:0] | 12'h0F0;
    m_adv();
    @(negedge clk);
    chk("R6 odd write busy", busy, 1);
    wr_char = 12'h00F;
    @(negedge clk);
    wr_stb = 0;
    chk("R11 strobe in merge ignored", char_ptr, 2);
    do_end(1'b0);
    do_load(24'(mk_da(0, 2, 0)), 1'b0, 1);
    do_conn();
    do_read();
    do_read();
    do_end(1'b0);

    // R8 in-track wrap
    do_load(24'(mk_da(3, 1, 3)), 1'b1, 1);
    do_conn();
    for (int k = 0; k < 16; k++) do_write(12'(12'h200 + k));
    chk("R8 sector wraps in track", disk_addr, mk_da(3, 1, 0));
    do_end(1'b0);

    // R7 track+sector wrap within unit
    do_load(24'(mk_da(2, 3, 3)), 1'b0, 1);
    do_conn();
    for (int k = 0; k < 16; k++) do_write(12'(12'h300 + k));
    chk("R7 wrap keeps unit", disk_addr, mk_da(2, 0, 0));
    do_end(1'b0);

    // R9 protected write
    wp_mask = 8'h01;
    do_load(24'(mk_da(0, 1, 3)), 1'b0, 1);
    do_conn();
    wr_stb = 1; wr_char = 12'hFFF;
    @(negedge clk);
    wr_stb = 0;
    chk("R9 abort pulse and error", {xfer_abort, err_flag, active}, 3'b110);
    chk("R9 ptr unchanged", char_ptr, 0);
    @(negedge clk);
    chk("R9 abort one cycle, err sticky", {xfer_abort, err_flag}, 2'b01);
    wp_mask = 8'h00;
    do_conn();
    chk("R3 connect clears error", err_flag, 0);
    do_read();
    do_read();
    do_end(1'b0);

    // R10 out of range read and write
    do_load(24'(mk_da(6, 0, 0)), 1'b0, 1);
    do_conn();
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    chk("R10 read abort", {xfer_abort, err_flag, active}, 3'b110);
    // R11 strobe while inactive
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    repeat (3) @(negedge clk);
    chk("R11 inactive read ignored", char_ptr, 0);
    do_load(24'(mk_da(7, 0, 0)), 1'b0, 1);
    do_conn();
    wr_stb = 1; wr_char = 12'h123;
    @(negedge clk);
    wr_stb = 0;
    chk("R10 write abort", {xfer_abort, err_flag}, 2'b11);

    // R12 partial write then fill
    do_load(24'(mk_da(0, 2, 1)), 1'b0, 1);
    do_conn();
    for (int k = 0; k < 16; k++) do_write(12'(12'hE00 + k));
    do_end(1'b0);
    do_load(24'(mk_da(0, 2, 1)), 1'b0, 1);
    do_conn();
    for (int k = 0; k < 5; k++) do_write(12'(12'h700 + k));
    for (int w = 3; w < 8; w++) shadow[int'(mk_da(0, 2, 1)) * 8 + w] = '0;
    m_ptr = 0; m_da = mk_da(0, 2, 2);
    do_end(1'b1);
    count_busy(n);
    chk("R12 fill busy cycles", n, 6);
    chk("R12 fill steps addr", {disk_addr, char_ptr}, {mk_da(0, 2, 2), 4'h0});
    do_load(24'(mk_da(0, 2, 1)), 1'b0, 1);
    do_conn();
    for (int k = 0; k < 16; k++) do_read();
    do_end(1'b0);

    // R12 zero pointer: no fill
    do_load(24'(mk_da(0, 2, 2)), 1'b0, 1);
    do_conn();
    do_end(1'b1);
    chk("R12 no fill at ptr 0", {busy, disk_addr}, {1'b0, mk_da(0, 2, 2)});

    // R12 odd pointer 15: nothing to clear, still steps
    do_conn();
    for (int k = 0; k < 15; k++) do_write(12'(12'h400 + k));
    do_end(1'b1);
    count_busy(n);
    chk("R12 fill at ptr 15 busy", n, 1);
    chk("R12 step after ptr 15", disk_addr, mk_da(0, 2, 3));

    repeat (4) @(negedge clk);
    chk("R5 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule